// File: doc/BRIEF.md
# Light-Load Rectifier Mode Controller

This block chooses, once per switching period, how the low-side switch of a synchronous buck stage behaves. In continuous conduction the low-side switch conducts for the whole off-time as a synchronous rectifier. In diode emulation the switch is held off, so it behaves like a diode and blocks inductor current from reversing. The modulator supplies a strobe once per PWM pulse. On each strobe the controller samples a phase-polarity flag, provided the low-side gate demand is high at that moment.

When the phase node reads positive on eight back-to-back strobes with the low-side gate on, the inductor current has reversed. The controller then switches to diode emulation. It clears the low-side gate enable mask and raises a window-step select, which tells the modulator to widen its window by about a third. One strobe with the gate demand on and the phase reading negative shows positive current in the body diode. That returns the controller to continuous conduction at the next clock. The enable input and reset both force continuous conduction.

The two states are `ST_CCM` (synchronous rectifier) and `ST_DEM` (emulated diode). There are two transitions. `T_ENTER` goes from `ST_CCM` to `ST_DEM` when the eighth consecutive qualifying strobe arrives while enabled. `T_EXIT` goes from `ST_DEM` to `ST_CCM` on a negative-phase strobe, or when enable is low.

Top module: `dem_mode_ctrl`

## Requirements
- R1: After reset, `dem_mode` is 0, `lg_en` is 1 and `win_step` is 0.
- R2: A strobe counts as qualifying when `enable`, `pulse_stb`, `lg_on` and `phase_pos` are all 1. The clock edge that samples the eighth consecutive qualifying strobe in continuous mode sets `dem_mode` to 1. Seven such strobes leave it at 0.
- R3: In continuous mode, a strobe with `lg_on`=1 and `phase_pos`=0, or a strobe with `lg_on`=0, clears the consecutive count. Eight further qualifying strobes are then needed to enter diode emulation.
- R4: A clock edge with `pulse_stb`=0 changes neither the mode nor the consecutive count, whatever `lg_on` and `phase_pos` are.
- R5: In diode emulation, a strobe with `lg_on`=1 and `phase_pos`=0 returns `dem_mode` to 0 at that clock edge. The count restarts from zero.
- R6: In diode emulation, a strobe with `phase_pos`=1, or a strobe with `lg_on`=0, keeps `dem_mode` at 1.
- R7: `lg_en` is 0 exactly while `dem_mode` is 1. `win_step` is 1 exactly while `dem_mode` is 1.
- R8: While `enable` is 0, the clock edge forces `dem_mode` to 0 and clears the count, and strobes are ignored. A low `enable` wins over a qualifying eighth strobe or any diode-mode strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; 0 forces continuous mode |
| pulse_stb | input | 1 | One-cycle strobe, once per PWM pulse |
| lg_on | input | 1 | Low-side gate demand from the modulator |
| phase_pos | input | 1 | 1 when the phase node is positive |
| dem_mode | output | 1 | 1 in diode emulation, 0 in continuous conduction |
| lg_en | output | 1 | Low-side gate enable mask (0 blocks the switch) |
| win_step | output | 1 | Window-voltage step select for the modulator |

## Verification
The colliding functions are the enable override and the pulse logic. The bench drives `enable` low in the same cycle as an eighth qualifying strobe, and also in the same cycle as a diode-mode strobe that would keep the mode. In both cases the mode must read continuous after that edge, and eight fresh strobes must then be needed to enter again. A sweep brings the controller to every count from zero to past eight, then applies all sixteen combinations of enable, strobe, gate and phase. After each clock it compares all three outputs with a bench model built from the requirements.

// File: rtl/dem_pkg.sv
package dem_pkg;
    typedef enum logic {
        ST_CCM = 1'b0,
        ST_DEM = 1'b1
    } dem_state_t;
endpackage

// File: rtl/dem_sample_decode.sv
module dem_sample_decode (
    input  logic enable,
    input  logic pulse_stb,
    input  logic lg_on,
    input  logic phase_pos,
    output logic obs_pos,
    output logic obs_neg,
    output logic obs_idle_gate
);
    logic sampled;

    always_comb begin
        sampled       = enable & pulse_stb;
        obs_pos       = sampled & lg_on & phase_pos;
        obs_neg       = sampled & lg_on & ~phase_pos;
        obs_idle_gate = sampled & ~lg_on;
    end
endmodule

// File: rtl/dem_run_counter.sv
module dem_run_counter #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CNT_W = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        hit = inc & ~clr & (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || hit) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dem_mode_fsm.sv
module dem_mode_fsm
    import dem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       run_hit,
    input  logic       obs_neg,
    output dem_state_t state,
    output logic       dem_mode,
    output logic       lg_en,
    output logic       win_step
);
    dem_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CCM: if (enable && run_hit) state_nx = ST_DEM;
            ST_DEM: if (!enable || obs_neg) state_nx = ST_CCM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CCM;
        else        state <= state_nx;
    end

    always_comb begin
        dem_mode = 1'b0;
        lg_en    = 1'b1;
        win_step = 1'b0;
        unique case (state)
            ST_CCM: begin
                dem_mode = 1'b0;
                lg_en    = 1'b1;
                win_step = 1'b0;
            end
            ST_DEM: begin
                dem_mode = 1'b1;
                lg_en    = 1'b0;
                win_step = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dem_mode_ctrl.sv
module dem_mode_ctrl
    import dem_pkg::*;
#(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pulse_stb,
    input  logic lg_on,
    input  logic phase_pos,
    output logic dem_mode,
    output logic lg_en,
    output logic win_step
);
    logic       obs_pos, obs_neg, obs_idle_gate;
    logic       run_hit, run_clr, run_inc;
    dem_state_t state;

    dem_sample_decode u_dec (
        .enable        (enable),
        .pulse_stb     (pulse_stb),
        .lg_on         (lg_on),
        .phase_pos     (phase_pos),
        .obs_pos       (obs_pos),
        .obs_neg       (obs_neg),
        .obs_idle_gate (obs_idle_gate)
    );

    // R3/R8: any non-qualifying strobe, diode mode, or disable clears the run
    always_comb begin
        run_inc = obs_pos & (state == ST_CCM);
        run_clr = ~enable | (state == ST_DEM) | obs_neg | obs_idle_gate;
    end

    dem_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .inc   (run_inc),
        .hit   (run_hit)
    );

    dem_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .run_hit  (run_hit),
        .obs_neg  (obs_neg),
        .state    (state),
        .dem_mode (dem_mode),
        .lg_en    (lg_en),
        .win_step (win_step)
    );
endmodule

// File: rtl/dem_mode_chk.sv
module dem_mode_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic pulse_stb,
    input logic lg_on,
    input logic phase_pos,
    input logic dem_mode,
    input logic lg_en,
    input logic win_step
);
    a_r7_mask_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_en == !dem_mode) && (win_step == dem_mode));

    a_r8_disable_forces_ccm: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !dem_mode);

    a_r5_negative_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_mode && enable && pulse_stb && lg_on && !phase_pos) |=> !dem_mode);

    a_r6_dem_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_mode && enable && !(pulse_stb && lg_on && !phase_pos)) |=> dem_mode);

    a_r4_no_entry_without_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
        (!dem_mode && !(enable && pulse_stb && lg_on && phase_pos)) |=> !dem_mode);
endmodule

bind dem_mode_ctrl dem_mode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pulse_stb (pulse_stb),
    .lg_on     (lg_on),
    .phase_pos (phase_pos),
    .dem_mode  (dem_mode),
    .lg_en     (lg_en),
    .win_step  (win_step)
);

// File: tb/sim_dem_mode_ctrl.sv
`timescale 1ns/1ps
module sim_dem_mode_ctrl;
    localparam int RUN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, pulse_stb = 1'b0, lg_on = 1'b0, phase_pos = 1'b0;
    logic dem_mode, lg_en, win_step;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    bit m_dem = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dem_mode_ctrl #(.RUN_LEN(RUN)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pulse_stb(pulse_stb),
        .lg_on(lg_on), .phase_pos(phase_pos),
        .dem_mode(dem_mode), .lg_en(lg_en), .win_step(win_step)
    );

    task automatic check_out(input string tag);
        checks++;
        if (dem_mode !== m_dem || lg_en !== !m_dem || win_step !== m_dem) begin
            failures++;
            $display("FAIL %s: mode/lg_en/win_step actual=%b%b%b expected=%b%b%b",
                     tag, dem_mode, lg_en, win_step, m_dem, !m_dem, m_dem);
        end
    endtask

    // drive on the falling edge, update the model, sample 1 ns after the rising edge
    task automatic step(input bit en, input bit stb, input bit lg, input bit ph);
        string tag;
        @(negedge clk);
        enable = en; pulse_stb = stb; lg_on = lg; phase_pos = ph;
        if (!en) tag = "R8";
        else if (!stb) tag = "R4";
        else if (m_dem) tag = (lg && !ph) ? "R5" : "R6";
        else tag = (lg && ph) ? "R2" : "R3";
        if (!en) begin
            m_dem = 1'b0; m_cnt = 0;
        end else if (stb) begin
            if (m_dem) begin
                if (lg && !ph) m_dem = 1'b0;
                m_cnt = 0;
            end else if (lg && ph) begin
                if (m_cnt == RUN - 1) begin m_dem = 1'b1; m_cnt = 0; end
                else m_cnt++;
            end else begin
                m_cnt = 0;
            end
        end
        @(posedge clk);
        #1;
        check_out(tag);
    endtask

    task automatic qual(input int n);
        for (int i = 0; i < n; i++) begin
            step(1, 1, 1, 1);
            step(1, 0, 0, 0);
        end
    endtask

    task automatic back_to_ccm();
        step(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_out("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_out("R1");

        // R2: seven do not enter, eighth does
        qual(7);
        if (dem_mode !== 1'b0) begin failures++; $display("FAIL R2: entered after seven, actual=%b expected=0", dem_mode); end
        checks++;
        qual(1);
        checks++;
        if (dem_mode !== 1'b1) begin failures++; $display("FAIL R2: eighth strobe, actual=%b expected=1", dem_mode); end

        // R6 then R5
        step(1, 1, 1, 1);
        step(1, 1, 0, 0);
        step(1, 0, 1, 0);
        step(1, 1, 1, 0);
        checks++;
        if (dem_mode !== 1'b0 || win_step !== 1'b0) begin failures++; $display("FAIL R5: exit actual=%b expected=0", dem_mode); end

        // R3: break after six, then needs eight more
        qual(6); step(1, 1, 1, 0); qual(7);
        checks++;
        if (dem_mode !== 1'b0) begin failures++; $display("FAIL R3: count not cleared actual=%b expected=0", dem_mode); end
        qual(1);
        qual(5); back_to_ccm();
        qual(6); step(1, 1, 0, 1); qual(7);
        checks++;
        if (dem_mode !== 1'b0) begin failures++; $display("FAIL R3: gate-off strobe did not clear actual=%b expected=0", dem_mode); end
        back_to_ccm();

        // R4: idle edges with arbitrary lg/phase keep the run
        qual(4);
        for (int k = 0; k < 4; k++) step(1, 0, k[0], k[1]);
        qual(4);
        checks++;
        if (dem_mode !== 1'b1) begin failures++; $display("FAIL R4: idle cycles broke run actual=%b expected=1", dem_mode); end

        // R8: collisions with disable
        step(0, 1, 1, 1);
        back_to_ccm();
        qual(7); step(0, 1, 1, 1); qual(7);
        checks++;
        if (dem_mode !== 1'b0) begin failures++; $display("FAIL R8: disable did not win actual=%b expected=0", dem_mode); end
        back_to_ccm();

        // sweep: every pre-count, then all 16 input combinations, then observe
        for (int pre = 0; pre <= RUN + 1; pre++) begin
            for (int c = 0; c < 16; c++) begin
                back_to_ccm();
                qual(pre);
                step(c[3], c[2], c[1], c[0]);
                qual(RUN - 1);
                step(1, 0, 0, 0);
            end
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule